// File: doc/BRIEF.md
# Tag System Word and Block Lock Controller

This block holds the word store of a contactless tag: sixteen 32-bit user words at block addresses 0 to 15 and one system word at block address 255. The system word carries, from the top down, a 16-bit lock field, an 8-bit reserved field and the 8-bit chip identifier. Writes to the system word can only clear bits: the stored value becomes the bitwise AND of the old contents and the written data. Each lock bit guards one user block. Bit 16+n at 0 makes block n read-only, and since lock bits cannot be set again, a guarded block stays read-only for good.

Clearing a lock bit does not guard its block at once. The block keeps an active protection register. This register takes a copy of the stored lock field only when a select event arrives whose candidate identifier equals the chip identifier. It also loads from the stored field at reset. The chip identifier is either a constant chosen by parameter or a value captured from a free-running 8-bit LFSR when the block leaves reset. Writes that are not accepted are dropped without effect and flagged by a one-cycle reject pulse. Reads return the stored word one cycle after the request. Storage is modelled as flip-flops.

Top module: `tag_sysblk_ctrl`

## Requirements
- R1: After reset every user block reads 0. The system word reads LOCK_INIT in bits 31..16, RSVD_INIT in bits 15..8 and the chip identifier in bits 7..0. The active protection output prot_o equals ~LOCK_INIT, where bit n at 1 means block n is protected.
- R2: A read request returns the addressed word on rd_data_o with rd_valid_o high in the cycle after the request, whether or not the block is protected. Addresses other than 0..15 and 255 read 0.
- R3: A write to user block n (0..15) whose prot_o bit is 0 replaces the whole word. wr_reject_o stays low.
- R4: A write to address 255 leaves bits 31..8 equal to the old bits AND the written bits 31..8. Bits 7..0 of the system word, which hold the chip identifier, are never changed by a write.
- R5: A system-word bit at 0 is never returned to 1 by any write. Once bits 31..8 are all 0, no write changes them.
- R6: While prot_o bit n is 1, a write to block n is dropped and the block's contents are unchanged. prot_o bits never go from 1 to 0.
- R7: A write to any address from 16 to 254 is dropped and raises wr_reject_o.
- R8: prot_o changes only in the cycle after a select event (sel_valid_i high) with sel_id_i equal to chip_id_o. It then takes the inverse of the stored lock field as it was before any write in the same cycle. A select with a different identifier has no effect.
- R9: With FIXED_ID_EN set, chip_id_o and bits 7..0 of the system word equal FIXED_ID, and the random source has no effect.
- R10: With FIXED_ID_EN clear, the identifier is the LFSR state at release of the internal reset. The LFSR starts at LFSR_SEED when rst_ni is released. It advances once per clock, shifting left, and bit 0 takes the XOR of bits 7, 5, 4 and 3. The internal reset is released SYNC_STAGES clocks after rst_ni, so the identifier is LFSR_SEED advanced SYNC_STAGES times.
- R11: wr_reject_o is high in the cycle after each dropped write. It is low in any cycle that follows an accepted write or no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Block address of the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Block address of the read |
| sel_valid_i | input | 1 | Select event |
| sel_id_i | input | 8 | Candidate identifier of the select event |
| rd_data_o | output | 32 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid |
| wr_reject_o | output | 1 | One-cycle pulse for a dropped write |
| chip_id_o | output | 8 | Chip identifier in use |
| prot_o | output | NUM_USER | Active per-block write protection, 1 = protected |

## Verification
The bench builds two copies of the block. The main copy uses the random identifier, seed 8'hA5, two reset stages and every lock bit at 1. In that copy the captured identifier, the gap between clearing a lock bit and committing it, and the fully cleared system word can all be reached through writes and selects. The second copy sets the fixed identifier 8'h3C and starts with lock bit 31 cleared. It shows the constant identifier inside the system word and a block that is already protected when reset ends.

// File: rtl/tag_sysblk_pkg.sv
package tag_sysblk_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ID_W-1:0]   chip_id_t;

  // One step of the identifier LFSR: shift left, feedback from taps 7,5,4,3.
  function automatic chip_id_t lfsr_advance(input chip_id_t cur);
    return {cur[ID_W-2:0], cur[7] ^ cur[5] ^ cur[4] ^ cur[3]};
  endfunction
endpackage

// File: rtl/tag_rst_sync.sv
module tag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tag_id_source.sv
module tag_id_source import tag_sysblk_pkg::*; #(
  parameter bit       FIXED_EN = 1'b0,
  parameter chip_id_t FIXED_ID = 8'h5A,
  parameter chip_id_t SEED     = 8'hA5
) (
  input  logic     clk_i,
  input  logic     rst_raw_ni,
  input  logic     rst_ni,
  output chip_id_t id_o
);
  generate
    if (FIXED_EN) begin : g_fixed
      assign id_o = FIXED_ID;
    end else begin : g_random
      chip_id_t lfsr_q, lfsr_d;
      chip_id_t id_q, id_d;
      logic     taken_q, taken_d;

      always_comb begin
        lfsr_d  = lfsr_advance(lfsr_q);
        id_d    = taken_q ? id_q : lfsr_q;
        taken_d = 1'b1;
      end

      // LFSR runs from the raw reset so it moves while the synchronizer holds.
      always_ff @(posedge clk_i or negedge rst_raw_ni) begin
        if (!rst_raw_ni) begin
          lfsr_q <= SEED;
        end else begin
          lfsr_q <= lfsr_d;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          id_q    <= SEED;
          taken_q <= 1'b0;
        end else if (!taken_q) begin
          id_q    <= id_d;
          taken_q <= taken_d;
        end
      end

      assign id_o = id_q;
    end
  endgenerate
endmodule

// File: rtl/tag_user_store.sv
module tag_user_store import tag_sysblk_pkg::*; #(
  parameter int unsigned NUM_BLK = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_BLK)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  word_t                     wr_data_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output word_t                     rd_word_o,
  output logic [NUM_BLK*WORD_W-1:0] blk_flat_o
);
  word_t blk_q [NUM_BLK];

  generate
    for (genvar n = 0; n < NUM_BLK; n++) begin : g_blk
      logic  en;
      word_t blk_d;

      always_comb begin
        en    = we_i && (wr_idx_i == IDX_W'(n));
        blk_d = wr_data_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          blk_q[n] <= '0;
        end else if (en) begin
          blk_q[n] <= blk_d;
        end
      end

      assign blk_flat_o[n*WORD_W +: WORD_W] = blk_q[n];
    end
  endgenerate

  assign rd_word_o = blk_q[rd_idx_i];
endmodule

// File: rtl/tag_sys_word.sv
module tag_sys_word #(
  parameter int unsigned LOCK_W    = 16,
  parameter int unsigned RSVD_W    = 8,
  parameter logic [LOCK_W-1:0] LOCK_INIT = '1,
  parameter logic [RSVD_W-1:0] RSVD_INIT = '1,
  localparam int unsigned UP_W     = LOCK_W + RSVD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [UP_W-1:0]   wr_bits_i,
  input  logic              commit_i,
  output logic [UP_W-1:0]   upper_o,
  output logic [LOCK_W-1:0] prot_o
);
  logic [UP_W-1:0]   upper_q, upper_d;
  logic [LOCK_W-1:0] prot_q, prot_d;
  logic [LOCK_W-1:0] lock_field;

  always_comb begin
    lock_field = upper_q[UP_W-1 -: LOCK_W];
    upper_d    = upper_q & wr_bits_i;
    prot_d     = ~lock_field;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= {LOCK_INIT, RSVD_INIT};
    end else if (we_i) begin
      upper_q <= upper_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= ~LOCK_INIT;
    end else if (commit_i) begin
      prot_q <= prot_d;
    end
  end

  assign upper_o = upper_q;
  assign prot_o  = prot_q;
endmodule

// File: rtl/tag_sysblk_ctrl.sv
module tag_sysblk_ctrl import tag_sysblk_pkg::*; #(
  parameter int unsigned NUM_USER    = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYS_ADDR    = 255,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          FIXED_ID_EN = 1'b0,
  parameter chip_id_t    FIXED_ID    = 8'h5A,
  parameter chip_id_t    LFSR_SEED   = 8'hA5,
  parameter logic [NUM_USER-1:0] LOCK_INIT = '1,
  parameter logic [WORD_W-NUM_USER-ID_W-1:0] RSVD_INIT = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                sel_valid_i,
  input  logic [ID_W-1:0]     sel_id_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                rd_valid_o,
  output logic                wr_reject_o,
  output logic [ID_W-1:0]     chip_id_o,
  output logic [NUM_USER-1:0] prot_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_USER);
  localparam int unsigned RSVD_W = WORD_W - NUM_USER - ID_W;
  localparam int unsigned UP_W   = NUM_USER + RSVD_W;

  logic                       rst_n;
  chip_id_t                   chip_id;
  logic [UP_W-1:0]            sys_upper;
  logic [NUM_USER*WORD_W-1:0] blk_flat;
  word_t                      user_rd_word;

  logic wr_is_user, wr_is_sys, blk_locked;
  logic user_we, sys_we, reject_d, sel_hit;
  logic rd_is_user, rd_is_sys;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  word_t rd_data_d;

  tag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  tag_id_source #(
    .FIXED_EN (FIXED_ID_EN),
    .FIXED_ID (FIXED_ID),
    .SEED     (LFSR_SEED)
  ) u_id (
    .clk_i      (clk_i),
    .rst_raw_ni (rst_ni),
    .rst_ni     (rst_n),
    .id_o       (chip_id)
  );

  // Write decode and protection gate.
  always_comb begin
    wr_is_user = wr_addr_i < ADDR_W'(NUM_USER);
    wr_is_sys  = wr_addr_i == ADDR_W'(SYS_ADDR);
    wr_idx     = wr_addr_i[IDX_W-1:0];
    blk_locked = prot_o[wr_idx];
    user_we    = wr_en_i && wr_is_user && !blk_locked;
    sys_we     = wr_en_i && wr_is_sys;
    reject_d   = wr_en_i && !user_we && !sys_we;
    sel_hit    = sel_valid_i && (sel_id_i == chip_id);
  end

  tag_user_store #(.NUM_BLK(NUM_USER)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .we_i       (user_we),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data_i),
    .rd_idx_i   (rd_idx),
    .rd_word_o  (user_rd_word),
    .blk_flat_o (blk_flat)
  );

  tag_sys_word #(
    .LOCK_W    (NUM_USER),
    .RSVD_W    (RSVD_W),
    .LOCK_INIT (LOCK_INIT),
    .RSVD_INIT (RSVD_INIT)
  ) u_sys (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .we_i      (sys_we),
    .wr_bits_i (wr_data_i[WORD_W-1:ID_W]),
    .commit_i  (sel_hit),
    .upper_o   (sys_upper),
    .prot_o    (prot_o)
  );

  // Read path.
  always_comb begin
    rd_is_user = rd_addr_i < ADDR_W'(NUM_USER);
    rd_is_sys  = rd_addr_i == ADDR_W'(SYS_ADDR);
    rd_idx     = rd_addr_i[IDX_W-1:0];
    if (rd_is_user) begin
      rd_data_d = user_rd_word;
    end else if (rd_is_sys) begin
      rd_data_d = {sys_upper, chip_id};
    end else begin
      rd_data_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      rd_data_o <= rd_data_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o  <= 1'b0;
      wr_reject_o <= 1'b0;
    end else begin
      rd_valid_o  <= rd_en_i;
      wr_reject_o <= reject_d;
    end
  end

  assign chip_id_o = chip_id;
endmodule

// File: rtl/tag_sysblk_ctrl_chk.sv
module tag_sysblk_ctrl_chk import tag_sysblk_pkg::*; #(
  parameter int unsigned NUM_USER    = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYS_ADDR    = 255,
  parameter bit          FIXED_ID_EN = 1'b0,
  parameter chip_id_t    FIXED_ID    = 8'h5A,
  localparam int unsigned UP_W       = WORD_W - ID_W
) (
  input logic                       clk_i,
  input logic                       rst_n,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [WORD_W-1:0]          wr_data_i,
  input logic                       rd_en_i,
  input logic                       rd_valid_o,
  input logic                       sel_valid_i,
  input logic [ID_W-1:0]            sel_id_i,
  input logic                       wr_reject_o,
  input logic [ID_W-1:0]            chip_id_o,
  input logic [NUM_USER-1:0]        prot_o,
  input logic [UP_W-1:0]            sys_upper,
  input logic [NUM_USER*WORD_W-1:0] blk_flat
);
  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  // R4
  sys_and_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADDR_W'(SYS_ADDR))
    |=> sys_upper == ($past(sys_upper) & $past(wr_data_i[WORD_W-1:ID_W])));

  // R5
  sys_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sys_upper & ~$past(sys_upper)) == '0);

  // R6
  prot_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (~prot_o & $past(prot_o)) == '0);

  // R7
  unmapped_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_addr_i >= ADDR_W'(NUM_USER) && wr_addr_i != ADDR_W'(SYS_ADDR))
    |=> wr_reject_o);

  // R8
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(sel_valid_i && sel_id_i == chip_id_o) |=> $stable(prot_o));

  // R8
  prot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_valid_i && sel_id_i == chip_id_o)
    |=> prot_o == ~$past(sys_upper[UP_W-1 -: NUM_USER]));

  // R11
  no_write_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en_i |=> !wr_reject_o);

  generate
    for (genvar n = 0; n < NUM_USER; n++) begin : g_blk_chk
      // R6
      locked_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        prot_o[n] |=> $stable(blk_flat[n*WORD_W +: WORD_W]));
    end
  endgenerate

  // R9
  always_comb begin
    if (FIXED_ID_EN) begin
      fixed_id_chk: assert (chip_id_o == FIXED_ID);
    end
  end
endmodule

bind tag_sysblk_ctrl tag_sysblk_ctrl_chk #(
  .NUM_USER    (NUM_USER),
  .ADDR_W      (ADDR_W),
  .SYS_ADDR    (SYS_ADDR),
  .FIXED_ID_EN (FIXED_ID_EN),
  .FIXED_ID    (FIXED_ID)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .rd_en_i     (rd_en_i),
  .rd_valid_o  (rd_valid_o),
  .sel_valid_i (sel_valid_i),
  .sel_id_i    (sel_id_i),
  .wr_reject_o (wr_reject_o),
  .chip_id_o   (chip_id_o),
  .prot_o      (prot_o),
  .sys_upper   (sys_upper),
  .blk_flat    (blk_flat)
);

// File: tb/tag_sysblk_ctrl_tb.sv
module tag_sysblk_ctrl_tb;
  localparam int NV = 28;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_S = 2'd2;

  // {req[3:0], op[1:0], addr[7:0], data[31:0], exp[31:0], exp_rej}
  // Select rows: addr 0 = matching id, 1 = wrong id; exp[15:0] = prot_o.
  localparam logic [78:0] TBL [NV] = '{
    {4'd3,  OP_W, 8'd3,   32'hDEADBEEF, 32'h0,        1'b0}, // R3
    {4'd2,  OP_R, 8'd3,   32'h0,        32'hDEADBEEF, 1'b0}, // R2
    {4'd4,  OP_W, 8'd255, 32'hFFFEFFFF, 32'h0,        1'b0}, // R4
    {4'd4,  OP_R, 8'd255, 32'h0,        32'hFFFEFF00, 1'b0}, // R4
    {4'd8,  OP_W, 8'd0,   32'h11111111, 32'h0,        1'b0}, // R8 not committed yet
    {4'd8,  OP_S, 8'd1,   32'h0,        32'h0000,     1'b0}, // R8 wrong id
    {4'd8,  OP_W, 8'd0,   32'h22222222, 32'h0,        1'b0}, // R8
    {4'd8,  OP_R, 8'd0,   32'h0,        32'h22222222, 1'b0}, // R8
    {4'd8,  OP_S, 8'd0,   32'h0,        32'h0001,     1'b0}, // R8 commit
    {4'd6,  OP_W, 8'd0,   32'h33333333, 32'h0,        1'b1}, // R6
    {4'd6,  OP_R, 8'd0,   32'h0,        32'h22222222, 1'b0}, // R6
    {4'd7,  OP_W, 8'd20,  32'hAAAA5555, 32'h0,        1'b1}, // R7
    {4'd2,  OP_R, 8'd20,  32'h0,        32'h0,        1'b0}, // R2
    {4'd7,  OP_W, 8'd254, 32'h1,        32'h0,        1'b1}, // R7
    {4'd4,  OP_W, 8'd255, 32'hFFFF00FF, 32'h0,        1'b0}, // R4
    {4'd4,  OP_R, 8'd255, 32'h0,        32'hFFFE0000, 1'b0}, // R4
    {4'd5,  OP_W, 8'd255, 32'hFFFFFFFF, 32'h0,        1'b0}, // R5
    {4'd5,  OP_R, 8'd255, 32'h0,        32'hFFFE0000, 1'b0}, // R5
    {4'd3,  OP_W, 8'd15,  32'hCAFEF00D, 32'h0,        1'b0}, // R3
    {4'd3,  OP_R, 8'd15,  32'h0,        32'hCAFEF00D, 1'b0}, // R3
    {4'd5,  OP_W, 8'd255, 32'h00000000, 32'h0,        1'b0}, // R5
    {4'd5,  OP_W, 8'd255, 32'hFFFFFFFF, 32'h0,        1'b0}, // R5
    {4'd5,  OP_R, 8'd255, 32'h0,        32'h00000000, 1'b0}, // R5
    {4'd8,  OP_W, 8'd1,   32'h12345678, 32'h0,        1'b0}, // R8
    {4'd8,  OP_S, 8'd0,   32'h0,        32'hFFFF,     1'b0}, // R8
    {4'd6,  OP_W, 8'd15,  32'h0,        32'h0,        1'b1}, // R6
    {4'd6,  OP_R, 8'd15,  32'h0,        32'hCAFEF00D, 1'b0}, // R6
    {4'd2,  OP_R, 8'd3,   32'h0,        32'hDEADBEEF, 1'b0}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, sel_valid;
  logic [7:0]  wr_addr, rd_addr, sel_id;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rd_valid, wr_reject;
  logic [7:0]  chip_id;
  logic [15:0] prot;

  logic        f_wr_en, f_rd_en;
  logic [7:0]  f_wr_addr, f_rd_addr;
  logic [31:0] f_wr_data, f_rd_data;
  logic        f_rd_valid, f_wr_reject;
  logic [7:0]  f_chip_id;
  logic [15:0] f_prot;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_id;

  always #10 clk = ~clk;

  tag_sysblk_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .sel_valid_i(sel_valid), .sel_id_i(sel_id),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .wr_reject_o(wr_reject),
    .chip_id_o(chip_id), .prot_o(prot)
  );

  tag_sysblk_ctrl #(
    .FIXED_ID_EN(1'b1), .FIXED_ID(8'h3C), .LOCK_INIT(16'h7FFF)
  ) u_fix (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(f_wr_en), .wr_addr_i(f_wr_addr), .wr_data_i(f_wr_data),
    .rd_en_i(f_rd_en), .rd_addr_i(f_rd_addr),
    .sel_valid_i(1'b0), .sel_id_i(8'h00),
    .rd_data_o(f_rd_data), .rd_valid_o(f_rd_valid), .wr_reject_o(f_wr_reject),
    .chip_id_o(f_chip_id), .prot_o(f_prot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Identifier LFSR as stated in R10.
  function automatic logic [7:0] id_after(input logic [7:0] seed, input int steps);
    logic [7:0] s = seed;
    for (int k = 0; k < steps; k++) s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    return s;
  endfunction

  task automatic idle_all();
    wr_en = 1'b0; rd_en = 1'b0; sel_valid = 1'b0;
    wr_addr = '0; rd_addr = '0; sel_id = '0; wr_data = '0;
    f_wr_en = 1'b0; f_rd_en = 1'b0; f_wr_addr = '0; f_rd_addr = '0; f_wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Drive one operation at a falling edge, let one rising edge pass, clear.
  task automatic do_op(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d,
                       input logic [7:0] sid);
    @(negedge clk);
    case (op)
      OP_W: begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
      OP_R: begin rd_en = 1'b1; rd_addr = a; end
      default: begin sel_valid = 1'b1; sel_id = sid; end
    endcase
    @(posedge clk);
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_all();
    exp_id = id_after(8'hA5, 2);
    do_reset();

    // R1 reset state, R10 captured identifier
    check("R10 chip_id", {24'h0, chip_id}, {24'h0, exp_id});
    check("R1 prot_o", {16'h0, prot}, 32'h0);
    for (int b = 0; b < 16; b++) begin
      do_op(OP_R, 8'(b), 32'h0, 8'h0);
      check("R1 user block", rd_data, 32'h0);
    end
    do_op(OP_R, 8'd255, 32'h0, 8'h0);
    check("R1 system word", rd_data, {24'hFFFFFF, exp_id});
    check("R2 rd_valid", {31'h0, rd_valid}, 32'h1);
    @(negedge clk);
    check("R2 rd_valid drop", {31'h0, rd_valid}, 32'h0);

    // R9 fixed identifier copy, R1 protection loaded at reset
    check("R9 fixed chip_id", {24'h0, f_chip_id}, 32'h3C);
    check("R1 fixed prot_o", {16'h0, f_prot}, 32'h8000);
    @(negedge clk); f_rd_en = 1'b1; f_rd_addr = 8'd255;
    @(posedge clk); @(negedge clk); idle_all();
    check("R9 fixed id in system word", f_rd_data, 32'h7FFFFF3C);
    @(negedge clk); f_wr_en = 1'b1; f_wr_addr = 8'd255; f_wr_data = 32'hFFFFFF00;
    @(posedge clk); @(negedge clk); idle_all();
    f_rd_en = 1'b1; f_rd_addr = 8'd255;
    @(posedge clk); @(negedge clk); idle_all();
    check("R4 id byte not writable", f_rd_data, 32'h7FFFFF3C);
    @(negedge clk); f_wr_en = 1'b1; f_wr_addr = 8'd15; f_wr_data = 32'h5;
    @(posedge clk); @(negedge clk); idle_all();
    check("R6 fixed locked block reject", {31'h0, f_wr_reject}, 32'h1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [78:0] v;
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] e;
      string       tag;
      v   = TBL[i];
      op  = v[74:73];
      a   = v[72:65];
      e   = v[32:1];
      tag = $sformatf("R%0d row %0d", v[78:75], i);
      do_op(op, a, v[64:33], (a == 8'd0) ? exp_id : (exp_id ^ 8'h01));
      case (op)
        OP_W: check(tag, {31'h0, wr_reject}, {31'h0, v[0]});
        OP_R: check(tag, rd_data, (a == 8'd255) ? {e[31:8], exp_id} : e);
        default: check(tag, {16'h0, prot}, {16'h0, e[15:0]});
      endcase
    end

    // R11 pulse lasts one cycle
    do_op(OP_W, 8'd40, 32'h0, 8'h0);
    check("R11 reject high", {31'h0, wr_reject}, 32'h1);
    @(negedge clk);
    check("R11 reject single cycle", {31'h0, wr_reject}, 32'h0);

    // R8 select in the same cycle as a lock write uses the older lock field
    do_reset();
    @(negedge clk);
    sel_valid = 1'b1; sel_id = exp_id;
    wr_en = 1'b1; wr_addr = 8'd255; wr_data = 32'hFFFDFFFF;
    @(posedge clk); @(negedge clk); idle_all();
    check("R8 same-cycle commit", {16'h0, prot}, 32'h0);
    do_op(OP_W, 8'd1, 32'hA1A1A1A1, 8'h0);
    check("R3 block 1 still open", {31'h0, wr_reject}, 32'h0);
    do_op(OP_S, 8'd0, 32'h0, exp_id);
    check("R8 later commit", {16'h0, prot}, 32'h0002);
    do_op(OP_W, 8'd1, 32'h0, 8'h0);
    check("R6 block 1 locked", {31'h0, wr_reject}, 32'h1);
    do_op(OP_R, 8'd1, 32'h0, 8'h0);
    check("R6 block 1 contents kept", rd_data, 32'hA1A1A1A1);

    done = 1'b1;
    summary();
  end
endmodule